// File: doc/BRIEF.md
# Register-Driven EEPROM Access Engine

This block lets a host reach an external byte-wide EEPROM through a few registers. The host can fetch or store one byte at a time. It places an address and, for a store, a data byte in registers, then sets a request bit. The hardware clears that bit when the access has finished. The EEPROM is reached through a simple request/acknowledge byte port. The serial wire protocol behind that port belongs to another block.

A second mode copies a table out of the EEPROM into on-chip memory. Each record in the table is two address bytes (high byte first) followed by one data byte. The data byte is written to a 24-bit internal address. That address joins a host-set base, which supplies the upper 9 bits, with the lower 15 bits of the record address. The copy stops at a record whose address is 0xFFFF, or when the last EEPROM location has been read. A burst starts at EEPROM location 0 when it is the first operation after reset. Otherwise it starts one past the last location touched. An internal watchdog abandons any access whose acknowledge does not arrive in time and raises an error flag.

Top module: `eeprom_access_engine`

Host register map (the select value is given on `reg_sel`):
- 0 control: bit0 write request, bit1 read request, bit2 busy (read-only), bit3 error (read-only).
- 1 data: 8 bits.
- 2 EEPROM address.
- 3 burst: bit0 start/active.
- 4 base: 9 bits.
- 5 watchdog limit.

Any other select value reads as 0.

## Requirements
- R1: After reset, select values 0 to 4 read 0 and select 5 reads the parameter WD_INIT. `ee_req` and `mem_we` are low.
- R2: Writing 1 to control bit1 while idle reads the EEPROM byte at the address register into the data register. Bit1 reads 1 until that byte is in place, then reads 0.
- R3: Writing control bit0 = 1 with bit1 = 0 while idle stores the data register at the address register, with `ee_we` high. Bit0 then clears itself.
- R4: The data register keeps only bits [7:0] of a host write, and bits [31:8] read as 0.
- R5: Writing bit0 = 1 to the burst register while idle starts a burst. Bit0 reads 1 while the burst runs and returns to 0 by itself.
- R6: A burst begins at EEPROM location 0 if it is the first operation since reset. Otherwise it begins one after the last location accessed by any single access or burst, wrapping past the top location to 0.
- R7: Each record of a burst is a high address byte, then a low address byte, then a data byte. It produces one `mem_we` pulse carrying the data, at address {base[8:0], record address[14:0]}. Bit 15 of the record address is ignored.
- R8: A record address of 0xFFFF ends the burst with no memory write. Reading the top EEPROM location also ends the burst, after that byte has been handled.
- R9: Control bit2 reads 1 from the accepted request until its completion. While it is 1, every host register write is ignored.
- R10: If `ee_ack` has not come within the watchdog limit (in cycles) of a request, the engine does three things: it drops `ee_req`, it clears the request and burst bits, and it sets control bit3. The next accepted request clears bit3.
- R11: While `ee_req` is high and unacknowledged, `ee_addr`, `ee_we` and `ee_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Selected register value |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | Request is a store |
| ee_addr | output | EE_AW | EEPROM byte location |
| ee_wdata | output | 8 | Byte to store |
| ee_ack | input | 1 | One-cycle completion pulse from the EEPROM side |
| ee_rdata | input | 8 | Fetched byte, valid with ee_ack |
| mem_we | output | 1 | Internal memory write pulse |
| mem_addr | output | 24 | Internal memory write address |
| mem_wdata | output | 8 | Internal memory write data |

## Verification
The assertions assume three things about the EEPROM side:
- `ee_ack` is a single-cycle pulse.
- `ee_ack` comes only while `ee_req` is high.
- After an acknowledge, the next acknowledge comes no sooner than the cycle after.

The bench model keeps to all three. It waits at least one cycle after each acknowledge and answers only a standing request. It never acknowledges in the cycle the engine consumes the previous one. A stall switch in the model withholds the acknowledge altogether so that the watchdog path can be reached. Host writes change inputs only at the falling edge.

// File: rtl/eeprom_access_engine.sv
module eeprom_access_engine #(
  parameter int EE_AW   = 16,
  parameter int MEM_AW  = 24,
  parameter int WDW     = 16,
  parameter int WD_INIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int LOW_W  = 15;
  localparam int BASE_W = MEM_AW - LOW_W;

  typedef enum logic [1:0] {S_IDLE, S_SINGLE, S_BURST} st_t;

  st_t              st;
  logic             rd_pend, wr_pend, err, req_q, we_q, memwe_q;
  logic [7:0]       data_q, hi_q, lo_q, memdata_q;
  logic [EE_AW-1:0] addr_q, cur, nxt;
  logic [BASE_W-1:0] base_q;
  logic [WDW-1:0]   wd_lim, wd_cnt;
  logic [1:0]       phase;
  logic [MEM_AW-1:0] memaddr_q;

  logic busy, bst_act, host_wr, go_rd, go_wr, go_bst, done_ack, timeout, term_hit, at_end;

  assign busy     = st != S_IDLE;
  assign bst_act  = st == S_BURST;
  assign host_wr  = reg_wr && !busy;
  assign go_rd    = host_wr && reg_sel == 3'd0 && reg_wdata[1];
  assign go_wr    = host_wr && reg_sel == 3'd0 && reg_wdata[0] && !reg_wdata[1];
  assign go_bst   = host_wr && reg_sel == 3'd3 && reg_wdata[0];
  assign done_ack = req_q && ee_ack;
  assign timeout  = req_q && !ee_ack && wd_cnt >= wd_lim;
  assign term_hit = bst_act && phase == 2'd1 && {hi_q, ee_rdata} == 16'hFFFF;
  assign at_end   = cur == {EE_AW{1'b1}};

  assign ee_req    = req_q;
  assign ee_we     = we_q;
  assign ee_addr   = cur;
  assign ee_wdata  = data_q;
  assign mem_we    = memwe_q;
  assign mem_addr  = memaddr_q;
  assign mem_wdata = memdata_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      3'd0: reg_rdata = {28'd0, err, busy, rd_pend, wr_pend};
      3'd1: reg_rdata = {24'd0, data_q};
      3'd2: reg_rdata = 32'(addr_q);
      3'd3: reg_rdata = {31'd0, bst_act};
      3'd4: reg_rdata = 32'(base_q);
      3'd5: reg_rdata = 32'(wd_lim);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rd_pend <= 1'b0; wr_pend <= 1'b0; err <= 1'b0;
      req_q <= 1'b0; we_q <= 1'b0; memwe_q <= 1'b0;
      data_q <= '0; hi_q <= '0; lo_q <= '0; memdata_q <= '0;
      addr_q <= '0; cur <= '0; nxt <= '0; base_q <= '0;
      wd_lim <= WDW'(WD_INIT); wd_cnt <= '0;
      phase <= '0; memaddr_q <= '0;
    end else begin
      memwe_q <= 1'b0;
      if (host_wr) begin
        case (reg_sel)
          3'd1: data_q <= reg_wdata[7:0];
          3'd2: addr_q <= reg_wdata[EE_AW-1:0];
          3'd4: base_q <= reg_wdata[BASE_W-1:0];
          3'd5: wd_lim <= reg_wdata[WDW-1:0];
          default: ;
        endcase
      end
      if (go_rd || go_wr) begin
        st <= S_SINGLE; rd_pend <= go_rd; wr_pend <= go_wr;
        req_q <= 1'b1; we_q <= go_wr; cur <= addr_q; err <= 1'b0; wd_cnt <= '0;
      end
      if (go_bst) begin
        st <= S_BURST; req_q <= 1'b1; we_q <= 1'b0; cur <= nxt;
        phase <= '0; err <= 1'b0; wd_cnt <= '0;
      end
      if (req_q) wd_cnt <= ee_ack ? '0 : wd_cnt + 1'b1;
      if (timeout) begin
        st <= S_IDLE; req_q <= 1'b0; rd_pend <= 1'b0; wr_pend <= 1'b0; err <= 1'b1;
      end
      if (done_ack) begin
        nxt <= cur + 1'b1;
        if (st == S_SINGLE) begin
          st <= S_IDLE; req_q <= 1'b0; rd_pend <= 1'b0; wr_pend <= 1'b0;
          if (!we_q) data_q <= ee_rdata;
        end else begin
          case (phase)
            2'd0: begin hi_q <= ee_rdata; phase <= 2'd1; end
            2'd1: begin lo_q <= ee_rdata; phase <= 2'd2; end
            default: begin
              memwe_q   <= 1'b1;
              memaddr_q <= {base_q, hi_q[6:0], lo_q};
              memdata_q <= ee_rdata;
              phase     <= 2'd0;
            end
          endcase
          if (term_hit || at_end) begin
            st <= S_IDLE; req_q <= 1'b0;
          end else begin
            cur <= cur + 1'b1;
          end
        end
      end
    end
  end
endmodule

module eeprom_access_engine_chk #(
  parameter int EE_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ee_req,
  input logic             ee_ack,
  input logic             ee_we,
  input logic [EE_AW-1:0] ee_addr,
  input logic [7:0]       ee_wdata,
  input logic             mem_we,
  input logic             busy,
  input logic             err,
  input logic             rd_pend,
  input logic             wr_pend,
  input logic             bst_act
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> !ee_req || ($stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));
  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> busy);
  p_memwe_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(ee_ack && ee_req));
  p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pend, wr_pend, bst_act}));
  p_err_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ee_req);
  p_store_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_we |-> wr_pend);
endmodule

bind eeprom_access_engine eeprom_access_engine_chk #(.EE_AW(EE_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_wdata(ee_wdata), .mem_we(mem_we), .busy(busy),
  .err(err), .rd_pend(rd_pend), .wr_pend(wr_pend), .bst_act(bst_act)
);

// File: tb/eeprom_access_engine_tb_top.sv
module eeprom_access_engine_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ee_req, ee_we, ee_ack = 1'b0, mem_we;
  logic [AW-1:0] ee_addr;
  logic [7:0] ee_wdata, ee_rdata = '0, mem_wdata;
  logic [23:0] mem_addr;

  int n_tests = 0, n_fail = 0;
  logic [7:0] eemem [0:255];
  int lat = 2, cnt = 0, fix_lat = 0;
  bit stall = 1'b0;
  logic [23:0] cap_a [0:15];
  logic [7:0]  cap_d [0:15];
  int cap_n = 0;

  always #5 clk = ~clk;

  eeprom_access_engine #(.EE_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req), .ee_we(ee_we),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) begin
    ee_ack <= 1'b0;
    if (ee_req && !ee_ack && !stall) begin
      if (cnt >= lat) begin
        ee_ack <= 1'b1;
        if (ee_we) eemem[ee_addr] <= ee_wdata;
        else ee_rdata <= eemem[ee_addr];
        cnt <= 0;
        lat <= (fix_lat != 0) ? fix_lat : int'($urandom_range(1, 4));
      end else cnt <= cnt + 1;
    end
  end

  always @(negedge clk) if (mem_we && cap_n < 16) begin
    cap_a[cap_n] = mem_addr; cap_d[cap_n] = mem_wdata; cap_n++;
  end

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [23:0] exp_maddr(input logic [8:0] b, input logic [7:0] h, input logic [7:0] l);
    return {b, h[6:0], l};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int k = 0;
    do begin rd_reg(3'd0, v); k++; end while (v[2] && k < 2000);
    check(!v[2], req, v, 32'h0);
  endtask

  task automatic do_burst(input string req);
    cap_n = 0;
    wr_reg(3'd3, 32'h1);
    wait_idle(req);
  endtask

  initial begin
    logic [31:0] v;
    logic [8:0] base = 9'h1A3;
    logic [7:0] a, d;
    for (int i = 0; i < 256; i++) eemem[i] = 8'(i * 37 + 5);
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 5; s++) begin rd_reg(3'(s), v); check(v == 0, "R1 reg", v, 0); end
    rd_reg(3'd5, v); check(v == 1000, "R1 wd limit", v, 1000);
    check(!ee_req && !mem_we, "R1 outputs", {ee_req, mem_we}, 0);

    // R6 R7 R8 first burst from location 0, top address bit ignored
    eemem[0] = 8'h12; eemem[1] = 8'h34; eemem[2] = 8'hAB;
    eemem[3] = 8'h80; eemem[4] = 8'h05; eemem[5] = 8'hCD;
    eemem[6] = 8'hFF; eemem[7] = 8'hFF;
    eemem[8] = 8'h00; eemem[9] = 8'h10; eemem[10] = 8'h5C;
    eemem[11] = 8'hFF; eemem[12] = 8'hFF;
    wr_reg(3'd4, 32'(base));
    cap_n = 0;
    wr_reg(3'd3, 32'h1);
    rd_reg(3'd3, v); check(v == 1, "R5 burst bit while running", v, 1);
    wait_idle("R5 burst ends");
    rd_reg(3'd3, v); check(v == 0, "R5 burst bit self-clear", v, 0);
    check(cap_n == 2, "R8 write count", cap_n, 2);
    check(cap_a[0] == exp_maddr(base, 8'h12, 8'h34) && cap_d[0] == 8'hAB, "R7 rec0", cap_a[0], exp_maddr(base, 8'h12, 8'h34));
    check(cap_a[1] == exp_maddr(base, 8'h80, 8'h05) && cap_d[1] == 8'hCD, "R7 rec1 msb ignored", cap_a[1], exp_maddr(base, 8'h80, 8'h05));

    // R6 second burst resumes at 8
    do_burst("R6 resume");
    check(cap_n == 1 && cap_a[0] == exp_maddr(base, 8'h00, 8'h10) && cap_d[0] == 8'h5C, "R6 resume after burst", cap_a[0], exp_maddr(base, 8'h00, 8'h10));

    // R2 R3 R4 random single accesses
    for (int it = 0; it < 8; it++) begin
      a = 8'($urandom_range(32, 200)); d = 8'($urandom);
      wr_reg(3'd2, 32'(a));
      wr_reg(3'd1, {24'hABCDEF, d});
      rd_reg(3'd1, v); check(v == {24'd0, d}, "R4 data width", v, {24'd0, d});
      wr_reg(3'd0, 32'h1);
      rd_reg(3'd0, v); check(v[0] && v[2], "R3 pending", v, 32'h5);
      wait_idle("R3 done");
      rd_reg(3'd0, v); check(v[1:0] == 0, "R3 self-clear", v, 0);
      check(eemem[a] == d, "R3 stored", eemem[a], d);
      wr_reg(3'd1, 32'h0);
      wr_reg(3'd0, 32'h2);
      rd_reg(3'd0, v); check(v[1], "R2 pending", v, 32'h6);
      wait_idle("R2 done");
      rd_reg(3'd1, v); check(v == {24'd0, d}, "R2 fetched", v, {24'd0, d});
    end

    // R6 burst after single access at 100
    eemem[101] = 8'h00; eemem[102] = 8'h44; eemem[103] = 8'h77;
    eemem[104] = 8'hFF; eemem[105] = 8'hFF;
    wr_reg(3'd2, 32'd100); wr_reg(3'd0, 32'h2); wait_idle("R2 at 100");
    do_burst("R6 after single");
    check(cap_n == 1 && cap_a[0] == exp_maddr(base, 8'h00, 8'h44) && cap_d[0] == 8'h77, "R6 after single", cap_a[0], exp_maddr(base, 8'h00, 8'h44));

    // R8 end of address space, then R6 wrap to 0
    eemem[252] = 8'h01; eemem[253] = 8'h23; eemem[254] = 8'h99; eemem[255] = 8'h05;
    wr_reg(3'd2, 32'd251); wr_reg(3'd0, 32'h2); wait_idle("R2 at 251");
    do_burst("R8 end of space");
    check(cap_n == 1 && cap_a[0] == exp_maddr(base, 8'h01, 8'h23) && cap_d[0] == 8'h99, "R8 end of space", cap_a[0], exp_maddr(base, 8'h01, 8'h23));
    do_burst("R6 wrap");
    check(cap_n == 2 && cap_d[0] == 8'hAB && cap_d[1] == 8'hCD, "R6 wrap to 0", cap_n, 2);

    // R9 writes ignored while busy
    d = eemem[40]; a = eemem[77];
    fix_lat = 15; lat = 15;
    wr_reg(3'd2, 32'd40); wr_reg(3'd0, 32'h2);
    wr_reg(3'd2, 32'd77); wr_reg(3'd1, 32'h11); wr_reg(3'd0, 32'h1);
    rd_reg(3'd0, v); check(v[2] == 1'b1, "R9 busy bit", v, 32'h6);
    wait_idle("R9 done");
    fix_lat = 0;
    rd_reg(3'd2, v); check(v == 40, "R9 addr kept", v, 40);
    rd_reg(3'd1, v); check(v == {24'd0, d}, "R9 data from read", v, {24'd0, d});
    check(eemem[77] == a, "R9 no store", eemem[77], a);

    // R10 watchdog
    wr_reg(3'd5, 32'd20);
    stall = 1'b1;
    wr_reg(3'd0, 32'h2);
    repeat (30) @(negedge clk);
    rd_reg(3'd0, v); check(v == 32'h8, "R10 abort flag", v, 32'h8);
    check(!ee_req, "R10 req dropped", ee_req, 0);
    stall = 1'b0; cnt = 0;
    wr_reg(3'd0, 32'h2); wait_idle("R10 retry");
    rd_reg(3'd0, v); check(v == 0, "R10 flag cleared", v, 0);
    rd_reg(3'd1, v); check(v == {24'd0, d}, "R10 retry data", v, {24'd0, d});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule